// File: doc/BRIEF.md
# Platform System Control Port Block

This block sits on a byte-wide I/O port bus of a legacy PC-style platform and answers accesses to a small, scattered set of system control and status ports. It decodes a 16-bit port address each cycle an access is presented and either updates internal state, fires a strobe, or prepares read data. Each port follows its own read-back rule: some return fixed identification constants, some store a masked value, some are write-only strobes, and one returns zero whatever was written.

Its outputs drive neighbouring platform logic: a soft-reset request line, a little-endian mode flag, a drive-activity indicator, an I/O map mode bit, and a one-cycle lock-toggle strobe with a 2-bit index for an external non-volatile memory. A flag pulses for any access that no port claims, so the bus fabric or a bench can see stray traffic. One access is presented per cycle; reads complete one cycle later with `rd_valid`. The bus never stalls, so the interface has no ready signal.

Top module: `syscon_ports`

## Requirements
- R1: After reset, soft_reset, le_mode, indicator, map_mode, lock_strobe, miss and rd_valid are all 0, rd_data is 0x00, the system control value and both scratch bytes are zero.
- R2: A write to port 0x0092 sets soft_reset to written bit 0 and le_mode to written bit 1 from the next cycle on; a read of 0x0092 returns 0x00.
- R3: Reads of the identification ports return fixed values: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03.
- R4: Writes to 0x0800, 0x0802, 0x0803 are accepted without any effect (no miss); writes to 0x080C, 0x0818, 0x0823 change nothing and raise miss.
- R5: A write to 0x0808 sets indicator to written bit 0; 0x0808 is write-only, so a read returns 0xFF and raises miss.
- R6: A write to 0x0810 or 0x0812 raises lock_strobe for exactly the next cycle with lock_idx 1 or 2 respectively and changes no read value; 0x0812 is write-only (read gives 0xFF and miss).
- R7: Port 0x081C stores the low 4 bits of a write and reads back {4'b0, stored}.
- R8: Port 0x0850 stores bit 0 as map_mode (0 contiguous, 1 non-contiguous) and reads back {7'b0, map_mode}.
- R9: Port 0x0814 accepts writes with no effect and reads 0xFF, without miss.
- R10: Ports 0x0398 and 0x0399 each return the last byte written to that port.
- R11: Any access to a port not listed above reads 0xFF, changes nothing, and raises miss for exactly the next cycle.
- R12: A read presented in one cycle gives rd_valid high in the next cycle with rd_data; rd_data holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Port address |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 8 | Read data, held until the next read |
| miss | output | 1 | Pulse: last access matched no port |
| soft_reset | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| indicator | output | 1 | Drive-activity indicator |
| map_mode | output | 1 | I/O map mode, 1 = non-contiguous |
| lock_strobe | output | 1 | One-cycle lock-toggle strobe |
| lock_idx | output | 2 | Lock index with the strobe (1 or 2) |

## Verification
Because strobes and the miss flag are registered pulses, the result of one access lands in the same cycle as the next access is accepted, so a lock strobe can coincide with a read response or with a miss pulse from a different access. The bench provokes this with back-to-back accesses: a lock write immediately followed by a read of an unassigned or write-only port, and two lock writes in a row so the strobe stays high while its index changes. A behavioural model predicts every output in every cycle and each coincident pulse is judged independently against it.

// File: rtl/syscon_pkg.sv
package syscon_pkg;

  typedef enum logic [3:0] {
    S_NONE,
    S_RSTEND,
    S_CPUCFG,
    S_FEAT,
    S_MODSTAT,
    S_EQUIP,
    S_KEYLOCK,
    S_L2STAT,
    S_LIGHT,
    S_LOCKA,
    S_LOCKB,
    S_L2INV,
    S_SYSCTL,
    S_MAPSEL,
    S_SCRATCH
  } sel_t;

  localparam logic [15:0] A_RSTEND  = 16'h0092;
  localparam logic [15:0] A_CPUCFG  = 16'h0800;
  localparam logic [15:0] A_FEAT    = 16'h0802;
  localparam logic [15:0] A_MODSTAT = 16'h0803;
  localparam logic [15:0] A_LIGHT   = 16'h0808;
  localparam logic [15:0] A_EQUIP   = 16'h080C;
  localparam logic [15:0] A_LOCKA   = 16'h0810;
  localparam logic [15:0] A_LOCKB   = 16'h0812;
  localparam logic [15:0] A_L2INV   = 16'h0814;
  localparam logic [15:0] A_KEYLOCK = 16'h0818;
  localparam logic [15:0] A_SYSCTL  = 16'h081C;
  localparam logic [15:0] A_L2STAT  = 16'h0823;
  localparam logic [15:0] A_MAPSEL  = 16'h0850;

  localparam logic [7:0] V_CPUCFG  = 8'hEF;
  localparam logic [7:0] V_FEAT    = 8'hAD;
  localparam logic [7:0] V_MODSTAT = 8'hE0;
  localparam logic [7:0] V_EQUIP   = 8'h3C;
  localparam logic [7:0] V_EXTFEAT = 8'h39;
  localparam logic [7:0] V_KEYLOCK = 8'h00;
  localparam logic [7:0] V_L2STAT  = 8'h03;
  localparam logic [7:0] V_EMPTY   = 8'hFF;

  function automatic logic read_claims(sel_t s);
    case (s)
      S_NONE, S_LIGHT, S_LOCKB: read_claims = 1'b0;
      default:                  read_claims = 1'b1;
    endcase
  endfunction

  function automatic logic write_claims(sel_t s);
    case (s)
      S_NONE, S_EQUIP, S_KEYLOCK, S_L2STAT: write_claims = 1'b0;
      default:                              write_claims = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/syscon_decode.sv
module syscon_decode
  import syscon_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SCR_N    = 2,
  parameter logic [ADDR_W-1:0] SCR_BASE = 16'h0398,
  localparam int SCR_IW  = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [SCR_IW-1:0] scr_idx
);

  logic [ADDR_W-1:0] scr_off;
  logic              scr_hit;

  assign scr_off = addr - SCR_BASE;
  assign scr_hit = (addr >= SCR_BASE) && (scr_off < ADDR_W'(SCR_N));
  assign scr_idx = scr_off[SCR_IW-1:0];

  always_comb begin
    sel = S_NONE;
    if (scr_hit) begin
      sel = S_SCRATCH;
    end else begin
      case (16'(addr))
        A_RSTEND:  sel = S_RSTEND;
        A_CPUCFG:  sel = S_CPUCFG;
        A_FEAT:    sel = S_FEAT;
        A_MODSTAT: sel = S_MODSTAT;
        A_LIGHT:   sel = S_LIGHT;
        A_EQUIP:   sel = S_EQUIP;
        A_LOCKA:   sel = S_LOCKA;
        A_LOCKB:   sel = S_LOCKB;
        A_L2INV:   sel = S_L2INV;
        A_KEYLOCK: sel = S_KEYLOCK;
        A_SYSCTL:  sel = S_SYSCTL;
        A_L2STAT:  sel = S_L2STAT;
        A_MAPSEL:  sel = S_MAPSEL;
        default:   sel = S_NONE;
      endcase
    end
  end

endmodule

// File: rtl/syscon_regs.sv
module syscon_regs
  import syscon_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SCTL_W  = 4,
  parameter int SCR_N   = 2,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  sel_t                         sel,
  input  logic [SCR_IW-1:0]            scr_idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         soft_reset,
  output logic                         le_mode,
  output logic                         indicator,
  output logic [SCTL_W-1:0]            sysctl,
  output logic                         map_mode,
  output logic [SCR_N-1:0][DATA_W-1:0] scratch,
  output logic                         lock_strobe,
  output logic [1:0]                   lock_idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_reset <= 1'b0;
      le_mode    <= 1'b0;
      indicator  <= 1'b0;
      sysctl     <= '0;
      map_mode   <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        S_RSTEND: begin
          soft_reset <= wdata[0];
          le_mode    <= wdata[1];
        end
        S_LIGHT:  indicator <= wdata[0];
        S_SYSCTL: sysctl    <= wdata[SCTL_W-1:0];
        S_MAPSEL: map_mode  <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_strobe <= 1'b0;
      lock_idx    <= 2'd0;
    end else begin
      lock_strobe <= wr_en && (sel == S_LOCKA || sel == S_LOCKB);
      if (wr_en && sel == S_LOCKA)      lock_idx <= 2'd1;
      else if (wr_en && sel == S_LOCKB) lock_idx <= 2'd2;
      else                              lock_idx <= 2'd0;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scratch[g] <= '0;
      end else if (wr_en && sel == S_SCRATCH && scr_idx == SCR_IW'(g)) begin
        scratch[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/syscon_rdmux.sv
module syscon_rdmux
  import syscon_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SCTL_W  = 4,
  parameter int SCR_N   = 2,
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  sel_t                         sel,
  input  logic [SCR_IW-1:0]            scr_idx,
  input  logic [SCTL_W-1:0]            sysctl,
  input  logic                         map_mode,
  input  logic [SCR_N-1:0][DATA_W-1:0] scratch,
  output logic [DATA_W-1:0]            rdata
);

  always_comb begin
    case (sel)
      S_RSTEND:  rdata = '0;
      S_CPUCFG:  rdata = DATA_W'(V_CPUCFG);
      S_FEAT:    rdata = DATA_W'(V_FEAT);
      S_MODSTAT: rdata = DATA_W'(V_MODSTAT);
      S_EQUIP:   rdata = DATA_W'(V_EQUIP);
      S_LOCKA:   rdata = DATA_W'(V_EXTFEAT);
      S_KEYLOCK: rdata = DATA_W'(V_KEYLOCK);
      S_L2STAT:  rdata = DATA_W'(V_L2STAT);
      S_SYSCTL:  rdata = DATA_W'(sysctl);
      S_MAPSEL:  rdata = DATA_W'(map_mode);
      S_SCRATCH: rdata = scratch[scr_idx];
      default:   rdata = DATA_W'(V_EMPTY);
    endcase
  end

endmodule

// File: rtl/syscon_ports.sv
module syscon_ports
  import syscon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SCTL_W = 4,
  parameter int SCR_N  = 2,
  parameter logic [ADDR_W-1:0] SCR_BASE = 16'h0398
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              miss,
  output logic              soft_reset,
  output logic              le_mode,
  output logic              indicator,
  output logic              map_mode,
  output logic              lock_strobe,
  output logic [1:0]        lock_idx
);

  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  sel_t                         sel;
  logic [SCR_IW-1:0]            scr_idx;
  logic [SCTL_W-1:0]            sysctl;
  logic [SCR_N-1:0][DATA_W-1:0] scratch;
  logic [DATA_W-1:0]            rdata_c;
  logic                         wr_en;
  logic                         rd_en;
  logic                         claimed;

  assign wr_en   = acc_valid && acc_write;
  assign rd_en   = acc_valid && !acc_write;
  assign claimed = acc_write ? write_claims(sel) : read_claims(sel);

  syscon_decode #(.ADDR_W(ADDR_W), .SCR_N(SCR_N), .SCR_BASE(SCR_BASE)) u_dec (
    .addr    (acc_addr),
    .sel     (sel),
    .scr_idx (scr_idx)
  );

  syscon_regs #(.DATA_W(DATA_W), .SCTL_W(SCTL_W), .SCR_N(SCR_N)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .sel         (sel),
    .scr_idx     (scr_idx),
    .wdata       (acc_wdata),
    .soft_reset  (soft_reset),
    .le_mode     (le_mode),
    .indicator   (indicator),
    .sysctl      (sysctl),
    .map_mode    (map_mode),
    .scratch     (scratch),
    .lock_strobe (lock_strobe),
    .lock_idx    (lock_idx)
  );

  syscon_rdmux #(.DATA_W(DATA_W), .SCTL_W(SCTL_W), .SCR_N(SCR_N)) u_rd (
    .sel      (sel),
    .scr_idx  (scr_idx),
    .sysctl   (sysctl),
    .map_mode (map_mode),
    .scratch  (scratch),
    .rdata    (rdata_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      miss     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      miss     <= acc_valid && !claimed;
      if (rd_en) rd_data <= rdata_c;
    end
  end

endmodule

// File: rtl/syscon_ports_chk.sv
module syscon_ports_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [15:0] acc_addr,
  input logic [7:0]  acc_wdata,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic        miss,
  input logic        soft_reset,
  input logic        le_mode,
  input logic        map_mode,
  input logic        lock_strobe,
  input logic [1:0]  lock_idx
);

  AST_RSTEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_write && acc_addr == 16'h0092) |-> (soft_reset == $past(acc_wdata[0]) && le_mode == $past(acc_wdata[1]))); // R2

  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_strobe |-> ($past(acc_valid && acc_write) && (lock_idx == 2'd1 || lock_idx == 2'd2))); // R6

  AST_SYSCTL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(acc_addr == 16'h081C)) |-> rd_data[7:4] == 4'h0); // R7

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && acc_write && acc_addr == 16'h0850) |-> $stable(map_mode)); // R8

  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> $past(acc_valid)); // R11

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write)); // R12

endmodule

bind syscon_ports syscon_ports_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .acc_wdata   (acc_wdata),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .miss        (miss),
  .soft_reset  (soft_reset),
  .le_mode     (le_mode),
  .map_mode    (map_mode),
  .lock_strobe (lock_strobe),
  .lock_idx    (lock_idx)
);

// File: tb/syscon_ports_test.sv
`timescale 1ns/1ps
module syscon_ports_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = 16'h0;
  logic [7:0]  acc_wdata = 8'h0;
  logic        rd_valid, miss, soft_reset, le_mode, indicator, map_mode, lock_strobe;
  logic [7:0]  rd_data;
  logic [1:0]  lock_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  syscon_ports uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .miss(miss), .soft_reset(soft_reset), .le_mode(le_mode), .indicator(indicator),
    .map_mode(map_mode), .lock_strobe(lock_strobe), .lock_idx(lock_idx)
  );

  // behavioural reference
  int    m_rst, m_le, m_light, m_map, m_sctl, m_strobe, m_idx, m_miss, m_rv, m_rd;
  int    m_scr [2];
  string m_rtag;

  function automatic string tag_of(int a);
    case (a)
      'h0092: return "R2";
      'h0800, 'h0802, 'h0803, 'h080C, 'h0810, 'h0818, 'h0823: return "R3";
      'h0808: return "R5";
      'h0812: return "R6";
      'h081C: return "R7";
      'h0850: return "R8";
      'h0814: return "R9";
      'h0398, 'h0399: return "R10";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst <= 0; m_le <= 0; m_light <= 0; m_map <= 0; m_sctl <= 0;
      m_strobe <= 0; m_idx <= 0; m_miss <= 0; m_rv <= 0; m_rd <= 0;
      m_scr[0] <= 0; m_scr[1] <= 0; m_rtag <= "R1";
    end else begin
      int a, d, hit, rv;
      a = acc_addr; d = acc_wdata; hit = 0; rv = 'hFF;
      m_strobe <= 0; m_idx <= 0;
      if (acc_valid && acc_write) begin
        case (a)
          'h0092: begin m_rst <= d & 1; m_le <= (d >> 1) & 1; hit = 1; end
          'h0800, 'h0802, 'h0803, 'h0814: hit = 1;
          'h0808: begin m_light <= d & 1; hit = 1; end
          'h0810: begin m_strobe <= 1; m_idx <= 1; hit = 1; end
          'h0812: begin m_strobe <= 1; m_idx <= 2; hit = 1; end
          'h081C: begin m_sctl <= d % 16; hit = 1; end
          'h0850: begin m_map <= d & 1; hit = 1; end
          'h0398: begin m_scr[0] <= d; hit = 1; end
          'h0399: begin m_scr[1] <= d; hit = 1; end
          default: hit = 0;
        endcase
      end else if (acc_valid) begin
        hit = 1;
        case (a)
          'h0092: rv = 0;
          'h0800: rv = 'hEF;
          'h0802: rv = 'hAD;
          'h0803: rv = 'hE0;
          'h080C: rv = 'h3C;
          'h0810: rv = 'h39;
          'h0818: rv = 0;
          'h0823: rv = 3;
          'h0814: rv = 'hFF;
          'h081C: rv = m_sctl;
          'h0850: rv = m_map;
          'h0398: rv = m_scr[0];
          'h0399: rv = m_scr[1];
          default: begin rv = 'hFF; hit = 0; end
        endcase
        m_rd <= rv; m_rtag <= tag_of(a);
      end
      m_rv   <= (acc_valid && !acc_write) ? 1 : 0;
      m_miss <= (acc_valid && !hit) ? 1 : 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "soft_reset", soft_reset, m_rst);
    chk("R2", "le_mode", le_mode, m_le);
    chk("R5", "indicator", indicator, m_light);
    chk("R8", "map_mode", map_mode, m_map);
    chk("R6", "lock_strobe", lock_strobe, m_strobe);
    if (m_strobe != 0) chk("R6", "lock_idx", lock_idx, m_idx);
    chk("R11", "miss", miss, m_miss);
    chk("R12", "rd_valid", rd_valid, m_rv);
    chk(m_rtag, "rd_data", rd_data, m_rd);
  endtask

  task automatic step(bit v, bit w, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    compare_all();
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d); step(1, 1, a, d); endtask
  task automatic rd(logic [15:0] a); step(1, 0, a, 8'h00); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, explicit values
    chk("R1", "reset soft_reset", soft_reset, 0);
    chk("R1", "reset le_mode", le_mode, 0);
    chk("R1", "reset map_mode", map_mode, 0);
    chk("R1", "reset rd_data", rd_data, 0);
    chk("R1", "reset strobe", lock_strobe, 0);
    // R1 stored values read zero
    rd(16'h081C); rd(16'h0398); rd(16'h0399); rd(16'h0850);
    step(0, 0, 0, 0);
    // R3 identification values
    rd(16'h0800); rd(16'h0802); rd(16'h0803); rd(16'h080C);
    rd(16'h0810); rd(16'h0818); rd(16'h0823);
    // R4 writes to identification ports
    wr(16'h0800, 8'h00); wr(16'h0802, 8'h11); wr(16'h0803, 8'h22);
    wr(16'h080C, 8'h33); wr(16'h0818, 8'h44); wr(16'h0823, 8'h55);
    rd(16'h0800); rd(16'h080C); rd(16'h0823);
    // R2 reset/endian port
    wr(16'h0092, 8'h01); wr(16'h0092, 8'h03); rd(16'h0092);
    wr(16'h0092, 8'hFE); wr(16'h0092, 8'h00);
    // R5 indicator
    wr(16'h0808, 8'hFF); rd(16'h0808); wr(16'h0808, 8'hFE);
    // R6 strobes, back-to-back and coincident with miss / read
    wr(16'h0810, 8'h5A); rd(16'h0812);
    wr(16'h0812, 8'h00); wr(16'h0810, 8'h00); rd(16'h0810);
    wr(16'h0810, 8'h00); rd(16'h1234);
    // R7 masking
    wr(16'h081C, 8'hA7); rd(16'h081C); wr(16'h081C, 8'hF0); rd(16'h081C);
    // R8 map mode
    wr(16'h0850, 8'hFF); rd(16'h0850); wr(16'h0850, 8'h02); rd(16'h0850);
    // R9 L2 invalidate
    wr(16'h0814, 8'h77); rd(16'h0814);
    // R10 scratch
    wr(16'h0398, 8'hC3); wr(16'h0399, 8'h5C); rd(16'h0398); rd(16'h0399);
    // R11 unassigned
    wr(16'h0801, 8'h12); rd(16'h0801); wr(16'h039A, 8'h99); rd(16'h039A);
    wr(16'h0397, 8'h01); rd(16'hFFFF); rd(16'h0000);
    // mixed traffic over the decoded area
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [15:0] a;
      pick = $urandom_range(0, 19);
      case (pick)
        0: a = 16'h0092;  1: a = 16'h0800;  2: a = 16'h0802;  3: a = 16'h0803;
        4: a = 16'h0808;  5: a = 16'h080C;  6: a = 16'h0810;  7: a = 16'h0812;
        8: a = 16'h0814;  9: a = 16'h0818; 10: a = 16'h081C; 11: a = 16'h0823;
       12: a = 16'h0850; 13: a = 16'h0398; 14: a = 16'h0399;
       15: a = 16'(16'h0800 + $urandom_range(0, 16'h60));
        default: a = 16'($urandom);
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, 8'($urandom));
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule